// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps wall-clock time and calendar date as packed BCD digits in 24-hour form: seconds, minutes, hours, day of week, date of month, month, two-digit year and a two-digit century. A prescaler counts enable pulses from a 32.768 kHz timebase into a one-second tick. Each tick advances a live counting set. Month lengths and leap years are applied automatically, and the Gregorian rule holds for every century value.

Software never touches the live set directly. It sees a second set of eight byte registers, the visible view, through a byte-wide port with a 3-bit offset, write and read strobes. On every second the view is refreshed from the live set. Two halt bits in the control byte stop that refresh. The read-halt bit gives software a stable snapshot while the live set keeps counting. The write-halt bit lets software stage a new time; clearing it copies the staged fields into the live set in one step. A stop bit in the seconds byte freezes the prescaler and the count.

Top module: `bcd_calendar_clock`

## Requirements
- R1: All time fields are BCD. Seconds and minutes wrap from 59 to 00 and hours from 23 to 00, each carrying into the next field. A units digit of 9 carries into the tens digit (09:59:59 becomes 10:00:00).
- R2: The date wraps to 01 after the last day of its month (30 for months 04, 06, 09, 11; 31 for the others except 02) and then carries into the month. Month 12 wraps to 01.
- R3: February ends on 29 in a leap year and on 28 otherwise. A year value of 00 is leap only when the century is divisible by 4 (2000 is leap, 2100 is not); any other year is leap when divisible by 4.
- R4: Year 99 wraps to 00 and increments the century. Century 39 wraps to 00. Day of week runs 01 to 07 and wraps from 07 to 01 at midnight.
- R5: One second elapses every TICKS_PER_SEC sampled `osc_en` pulses. The pulse count restarts from zero while the clock is stopped.
- R6: While control bit 6 (read-halt) is 1, the visible view is not refreshed but the live count keeps advancing. After the bit is cleared, the view shows the live count from the next second boundary on.
- R7: While control bit 7 (write-halt) is 1, the visible view is not refreshed. A control write with bit 7 = 0 while write-halt is set copies the visible time fields into the live count, with the century taken from bits 5:0 of that same write.
- R8: Bit 7 of the seconds byte stops the clock when 1 and runs it when 0. It resets to 1.
- R9: Offsets are 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Time bits per offset are 5:0, 6:0, 6:0, 5:0, 2:0, 5:0, 4:0, 7:0. All other bits read back as last written and are never changed by a refresh.
- R10: After reset the bytes read 00, 80, 00, 00, 01, 01, 01, 00 for offsets 0 to 7. `rdata` is 00 whenever `rd_en` is low.
- R11: A write to a time byte while neither halt bit is set changes only the visible view. The next refresh replaces it with the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe, qualifies `rdata` combinationally |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the visible view |

## Verification
Calendar stepping is tried by loading times just before midnight on chosen dates. February 28 and 29 are loaded in a leap year, a non-leap year, a leap century (2000) and a non-leap century (2100). Year-end cases cover the century increment and the century 39 wrap. Together these separate a plain divide-by-four leap rule from the full rule, and month-length errors from carry-chain errors. Read-halt is held across ten seconds to show that the snapshot is constant while the live count moves on. Direct writes with no halt, spare-bit writes and the stop bit show what a refresh may and may not overwrite. A behavioural model compares every read on every clock.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

  localparam int BYTE_W    = 8;
  localparam int REG_BYTES = 8;
  localparam int ADDR_W    = $clog2(REG_BYTES);
  localparam int VIEW_W    = REG_BYTES * BYTE_W;

  // register offsets (field positions below match these)
  localparam int OFS_CTRL = 0;
  localparam int OFS_SEC  = 1;
  localparam int OFS_MIN  = 2;
  localparam int OFS_HOUR = 3;
  localparam int OFS_WDAY = 4;
  localparam int OFS_DATE = 5;
  localparam int OFS_MON  = 6;
  localparam int OFS_YEAR = 7;

  localparam int CTRL_WHALT_BIT = 7;
  localparam int CTRL_RHALT_BIT = 6;
  localparam int SEC_STOP_BIT   = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  // packed so that byte k sits at bits [8k+7:8k], matching offset k
  typedef struct packed {
    byte_t yr;
    byte_t mon;
    byte_t date;
    byte_t wday;
    byte_t hour;
    byte_t min;
    byte_t sec;
    byte_t cen;
  } cal_time_t;

  localparam cal_time_t LIVE_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                       wday: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00, cen: 8'h00};

  // bits of each byte that carry time digits
  function automatic byte_t time_bits(input int ofs);
    case (ofs)
      OFS_CTRL: return 8'h3F;
      OFS_SEC:  return 8'h7F;
      OFS_MIN:  return 8'h7F;
      OFS_HOUR: return 8'h3F;
      OFS_WDAY: return 8'h07;
      OFS_DATE: return 8'h3F;
      OFS_MON:  return 8'h1F;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic byte_t view_reset(input int ofs);
    case (ofs)
      OFS_SEC:                     return 8'h80;
      OFS_WDAY, OFS_DATE, OFS_MON: return 8'h01;
      default:                     return 8'h00;
    endcase
  endfunction

  function automatic byte_t bcd_step(input byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10*t + u) mod 4 == (2*t + u) mod 4
  function automatic logic [1:0] bcd_mod4(input byte_t v);
    logic [4:0] s;
    s = {v[7:4], 1'b0} + 5'(v[3:0]);
    return s[1:0];
  endfunction

  function automatic logic is_leap(input byte_t cen, input byte_t yr);
    if (yr == 8'h00) return bcd_mod4(cen) == 2'd0;
    return bcd_mod4(yr) == 2'd0;
  endfunction

  function automatic byte_t month_last(input byte_t mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic cal_time_t advance(input cal_time_t t);
    cal_time_t n;
    n = t;
    if (t.sec < 8'h59) n.sec = bcd_step(t.sec);
    else begin
      n.sec = 8'h00;
      if (t.min < 8'h59) n.min = bcd_step(t.min);
      else begin
        n.min = 8'h00;
        if (t.hour < 8'h23) n.hour = bcd_step(t.hour);
        else begin
          n.hour = 8'h00;
          n.wday = (t.wday >= 8'h07) ? 8'h01 : bcd_step(t.wday);
          if (t.date < month_last(t.mon, is_leap(t.cen, t.yr))) n.date = bcd_step(t.date);
          else begin
            n.date = 8'h01;
            if (t.mon < 8'h12) n.mon = bcd_step(t.mon);
            else begin
              n.mon = 8'h01;
              if (t.yr < 8'h99) n.yr = bcd_step(t.yr);
              else begin
                n.yr  = 8'h00;
                n.cen = (t.cen >= 8'h39) ? 8'h00 : bcd_step(t.cen);
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic cal_time_t bytes_to_time(input logic [VIEW_W-1:0] raw);
    logic [VIEW_W-1:0] m;
    for (int i = 0; i < REG_BYTES; i++)
      m[i*BYTE_W +: BYTE_W] = raw[i*BYTE_W +: BYTE_W] & time_bits(i);
    return cal_time_t'(m);
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic osc_en,
  output logic sec_tick
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last  = (cnt == LAST);
  assign sec_tick = run && osc_en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (osc_en) cnt <= at_last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_clock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_tick,
  input  logic      commit,
  input  cal_time_t load_val,
  output cal_time_t live,
  output cal_time_t stepped
);
  assign stepped = advance(live);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        live <= LIVE_RESET;
    else if (commit)   live <= load_val;
    else if (sec_tick) live <= stepped;
  end
endmodule

// File: rtl/cal_user_bank.sv
module cal_user_bank
  import cal_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  logic              refresh,
  input  cal_time_t         fresh,
  output logic [VIEW_W-1:0] view
);
  logic [VIEW_W-1:0] fresh_raw;
  assign fresh_raw = fresh;

  for (genvar i = 0; i < REG_BYTES; i++) begin : g_byte
    localparam byte_t KEEP = time_bits(i);
    localparam byte_t INIT = view_reset(i);
    byte_t q;
    byte_t fresh_b;
    assign fresh_b = fresh_raw[i*BYTE_W +: BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= INIT;
      else if (wr_en && addr == ADDR_W'(i))     q <= wdata;
      else if (refresh)                         q <= (q & ~KEEP) | (fresh_b & KEEP);
    end

    assign view[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [VIEW_W-1:0] view;
  cal_time_t         live_time;
  cal_time_t         stepped_time;
  cal_time_t         load_time;
  logic              sec_tick;
  logic              commit_evt;
  logic              refresh_evt;
  logic              osc_stopped;
  logic              wr_halt;
  logic              rd_halt;

  assign wr_halt     = view[OFS_CTRL*BYTE_W + CTRL_WHALT_BIT];
  assign rd_halt     = view[OFS_CTRL*BYTE_W + CTRL_RHALT_BIT];
  assign osc_stopped = view[OFS_SEC*BYTE_W + SEC_STOP_BIT];

  assign commit_evt  = wr_en && (addr == ADDR_W'(OFS_CTRL)) && wr_halt && !wdata[CTRL_WHALT_BIT];
  assign refresh_evt = sec_tick && !wr_halt && !rd_halt;

  always_comb begin
    load_time     = bytes_to_time(view);
    load_time.cen = wdata & time_bits(OFS_CTRL);
  end

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!osc_stopped),
    .osc_en   (osc_en),
    .sec_tick (sec_tick)
  );

  cal_time_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .commit   (commit_evt),
    .load_val (load_time),
    .live     (live_time),
    .stepped  (stepped_time)
  );

  cal_user_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .refresh (refresh_evt),
    .fresh   (stepped_time),
    .view    (view)
  );

  always_comb rdata = rd_en ? view[{addr, 3'b000} +: BYTE_W] : '0;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_clock_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wdata,
  input logic              sec_tick,
  input logic              commit_evt,
  input logic              osc_stopped,
  input logic              rd_halt,
  input logic              wr_halt,
  input cal_time_t         live_time,
  input logic [VIEW_W-1:0] view
);
  AST_LIVE_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (live_time.sec[3:0] <= 4'd9) && (live_time.sec <= 8'h59)); // R1

  AST_LIVE_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_time.date >= 8'h01) && (live_time.date <= 8'h31)); // R2

  AST_LIVE_CEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    live_time.cen <= 8'h39); // R4

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stopped |-> !sec_tick); // R8

  AST_VIEW_FROZEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_halt && !wr_en) |=> $stable(view)); // R6

  AST_LIVE_RUNS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_halt && sec_tick && !commit_evt) |=> (live_time.sec != $past(live_time.sec))); // R6

  AST_VIEW_FROZEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_halt && !wr_en) |=> $stable(view)); // R7

  AST_COMMIT_CENTURY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (live_time.cen == ($past(wdata) & 8'h3F))); // R7
endmodule

bind bcd_calendar_clock cal_clock_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wdata       (wdata),
  .sec_tick    (sec_tick),
  .commit_evt  (commit_evt),
  .osc_stopped (osc_stopped),
  .rd_halt     (rd_halt),
  .wr_halt     (wr_halt),
  .live_time   (live_time),
  .view        (view)
);

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  // timebase enable: one pulse every other clock
  always @(posedge clk) begin
    #1;
    osc_en = ~osc_en;
  end

  // ---------------- behavioural reference model ----------------
  int m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y, m_c, m_pre;
  logic [7:0] mu [8];
  logic [7:0] old_ctrl;
  bit m_tick, m_cmt;

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(input int mo, input int full_year);
    bit leap;
    leap = ((full_year % 4 == 0) && (full_year % 100 != 0)) || (full_year % 400 == 0);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_wd = (m_wd % 7) + 1;
    m_d++;
    if (m_d <= days_in(m_mo, m_c * 100 + m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y++;
    if (m_y < 100) return;
    m_y = 0; m_c = (m_c + 1) % 40;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = 0; m_mi = 0; m_h = 0; m_wd = 1; m_d = 1; m_mo = 1; m_y = 0; m_c = 0; m_pre = 0;
      mu[0] = 8'h00; mu[1] = 8'h80; mu[2] = 8'h00; mu[3] = 8'h00;
      mu[4] = 8'h01; mu[5] = 8'h01; mu[6] = 8'h01; mu[7] = 8'h00;
    end else begin
      old_ctrl = mu[0];
      m_tick = 1'b0;
      if (mu[1][7]) m_pre = 0;
      else if (osc_en) begin
        if (m_pre == TPS - 1) begin m_tick = 1'b1; m_pre = 0; end
        else m_pre++;
      end
      m_cmt = wr_en && (addr == 3'd0) && old_ctrl[7] && !wdata[7];
      if (m_cmt) begin
        m_c  = from_bcd(wdata & 8'h3F);
        m_s  = from_bcd(mu[1] & 8'h7F);
        m_mi = from_bcd(mu[2] & 8'h7F);
        m_h  = from_bcd(mu[3] & 8'h3F);
        m_wd = from_bcd(mu[4] & 8'h07);
        m_d  = from_bcd(mu[5] & 8'h3F);
        m_mo = from_bcd(mu[6] & 8'h1F);
        m_y  = from_bcd(mu[7]);
      end else if (m_tick) begin
        model_step();
        if (!old_ctrl[7] && !old_ctrl[6]) begin
          mu[0] = (mu[0] & 8'hC0) | to_bcd(m_c);
          mu[1] = (mu[1] & 8'h80) | to_bcd(m_s);
          mu[2] = (mu[2] & 8'h80) | to_bcd(m_mi);
          mu[3] = (mu[3] & 8'hC0) | to_bcd(m_h);
          mu[4] = (mu[4] & 8'hF8) | to_bcd(m_wd);
          mu[5] = (mu[5] & 8'hC0) | to_bcd(m_d);
          mu[6] = (mu[6] & 8'hE0) | to_bcd(m_mo);
          mu[7] = to_bcd(m_y);
        end
      end
      if (wr_en) mu[addr] = wdata;
    end
  end

  // every-clock comparison of the read port against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_en && rdata !== mu[addr]) begin
        fails++;
        $display("FAIL R9 clock compare offset %0d: got %02h expected %02h", addr, rdata, mu[addr]);
      end else if (!rd_en && rdata !== 8'h00) begin
        fails++;
        $display("FAIL R10 idle read port: got %02h expected 00", rdata);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = 3'(a); wdata = d; wr_en = 1'b1; rd_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(posedge clk); #1;
    addr = 3'(a); wr_en = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      wr_en = 1'b0; rd_en = 1'b1; addr = addr + 3'd1;
    end
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, d, wd, h, mi, s);
    wr(0, 8'h80 | c);
    wr(7, y); wr(6, mo); wr(5, d); wr(4, wd);
    wr(3, h); wr(2, mi); wr(1, s);
    wr(0, c);
  endtask

  task automatic roll(input string req, input logic [7:0] c, y, mo, d, wd,
                      input logic [7:0] ec, ey, emo, ed, ewd);
    logic [7:0] v;
    set_time(c, y, mo, d, wd, 8'h23, 8'h59, 8'h59);
    idle(8);
    rd(5, v); chk({req, " date"}, v, ed);
    rd(6, v); chk({req, " month"}, v, emo);
    rd(7, v); chk({req, " year"}, v, ey);
    rd(0, v); chk({req, " century"}, v, ec);
    rd(4, v); chk({req, " weekday"}, v, ewd);
    rd(3, v); chk({req, " hour"}, v, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v, a0, a1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state and idle read port
    @(negedge clk);
    chk("R10 rdata with rd_en low", rdata, 8'h00);
    rd(0, v); chk("R10 control", v, 8'h00);
    rd(1, v); chk("R10 seconds stopped", v, 8'h80);
    rd(2, v); chk("R10 minutes", v, 8'h00);
    rd(4, v); chk("R10 weekday", v, 8'h01);
    rd(5, v); chk("R10 date", v, 8'h01);
    rd(6, v); chk("R10 month", v, 8'h01);
    rd(7, v); chk("R10 year", v, 8'h00);

    // R8: stays stopped from reset
    idle(30);
    rd(1, v); chk("R8 stopped after reset", v, 8'h80);

    // R5: one second per TPS pulses
    wr(1, 8'h00);
    idle(4);
    rd(1, v); chk("R5 before first second", v, 8'h00);
    idle(8);
    rd(1, v); chk("R5 after one second", v, 8'h01);

    // R1: digit and field carries
    set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h09, 8'h59, 8'h59);
    idle(8);
    rd(3, v); chk("R1 hour 09->10", v, 8'h10);
    rd(2, v); chk("R1 minute wrap", v, 8'h00);
    rd(5, v); chk("R1 date unchanged", v, 8'h15);

    // R2: month lengths
    roll("R2 Apr 30", 8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h20, 8'h24, 8'h05, 8'h01, 8'h03);
    roll("R2 Jan 31", 8'h20, 8'h24, 8'h01, 8'h31, 8'h05, 8'h20, 8'h24, 8'h02, 8'h01, 8'h06);

    // R3: leap rules
    roll("R3 2023 Feb 28", 8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h20, 8'h23, 8'h03, 8'h01, 8'h03);
    roll("R3 2024 Feb 28", 8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h20, 8'h24, 8'h02, 8'h29, 8'h04);
    roll("R3 2024 Feb 29", 8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h20, 8'h24, 8'h03, 8'h01, 8'h05);
    roll("R3 2100 Feb 28", 8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h21, 8'h00, 8'h03, 8'h01, 8'h02);
    roll("R3 2000 Feb 28", 8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h20, 8'h00, 8'h02, 8'h29, 8'h02);

    // R4: year, century and weekday wraps
    roll("R4 2099 end", 8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h21, 8'h00, 8'h01, 8'h01, 8'h01);
    roll("R4 3999 end", 8'h39, 8'h99, 8'h12, 8'h31, 8'h06, 8'h00, 8'h00, 8'h01, 8'h01, 8'h07);

    // R6: frozen snapshot while live count continues
    set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h00);
    idle(8);
    wr(0, 8'h60);
    idle(2);
    rd(1, a0);
    idle(80);
    rd(1, a1);
    chk("R6 seconds frozen over ten seconds", a1, a0);
    rd(2, v); chk("R6 minutes frozen", v, 8'h20);
    wr(0, 8'h20);
    idle(8);
    rd(1, v);
    chk("R6 view caught up with live count", v, mu[1]);
    checks++;
    if (v == a0) begin
      fails++;
      $display("FAIL R6 view did not move after release: got %02h expected not %02h", v, a0);
    end

    // R7: write-halt blocks refresh, release commits
    wr(0, 8'h80 | 8'h20);
    idle(2);
    rd(1, a0);
    idle(24);
    rd(1, a1);
    chk("R7 view held under write-halt", a1, a0);
    wr(2, 8'h33);
    wr(1, 8'h10);
    wr(0, 8'h19);
    idle(8);
    rd(2, v); chk("R7 committed minutes", v, 8'h33);
    rd(1, v); chk("R7 committed seconds advanced", v, 8'h11);
    rd(0, v); chk("R7 committed century", v, 8'h19);

    // R11: direct write with no halt is overwritten by refresh
    set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h05);
    idle(2);
    wr(2, 8'h45);
    rd(2, v); chk("R11 direct write visible", v, 8'h45);
    idle(8);
    rd(2, v); chk("R11 refresh restores live minutes", v, 8'h20);

    // R9: spare bits survive refresh
    wr(3, 8'hD0);
    idle(8);
    rd(3, v); chk("R9 hour spare bits kept", v, 8'hD0);
    wr(4, 8'hF8 | 8'h03);
    idle(8);
    rd(4, v); chk("R9 weekday spare bits kept", v, 8'hFB);

    // R8: stop bit freezes count, clearing resumes
    wr(1, 8'hB0);
    idle(40);
    rd(1, v); chk("R8 stopped seconds", v, 8'hB0);
    rd(2, v); chk("R8 stopped minutes", v, 8'h20);
    wr(1, 8'h30);
    idle(10);
    rd(1, v); chk("R8 running again", v, mu[1]);

    idle(4);
    done = 1'b1;
    summary();
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    done = 1'b1;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule